// File: doc/BRIEF.md
# MII Management Access Sequencer

This block lets a host reach the 16-bit registers of an Ethernet PHY over the two-wire management interface (MDC clock, bidirectional MDIO data). The host sees seven byte-wide locations. To write a PHY register it fills in the register number, then the low data byte, then the high data byte. Writing the high byte launches the write frame. To read, it sets the read bit of the command location. It then polls the status location until the busy flag drops, clears the read bit and collects the result as two bytes.

Every transaction is one 64-bit management frame: 32 preamble ones, start pattern `01`, opcode (`10` read, `01` write), a 5-bit PHY address (parameter, default 0), the 5-bit register number, a two-bit turnaround and 16 data bits, most significant bit first. MDC runs at the system clock divided by `CLK_DIV` only while a frame is in flight. MDIO is updated only after a falling MDC edge. A scan request bit exists in the command location but starts nothing.

Top module: `mii_mgmt_seq`

## Requirements
- R1: After reset every host location (offsets 0 to 6) reads 0x00, MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: Writing offset 3 (write-data high) while idle sends a write frame: 32 ones, `01`, `01`, PHY address, register number from offset 1, turnaround `10`, then {offset 3 byte, offset 2 byte}, all bits driven and sent MSB first.
- R3: Writing offset 0 with bit 0 set while idle sends a read frame (`01`, `10`, PHY address, register number) and releases MDIO for the last 18 bit times. The 16 bits sampled on the rising MDC edges of the data field appear at offset 5 (high byte) and offset 4 (low byte).
- R4: Status bit 0 (busy) at offset 6 is set from the clock cycle after the starting write and stays set for exactly 64 × `CLK_DIV` cycles.
- R5: Status bit 2 (read data not valid) is set while a read frame is in flight and is clear once its result has been stored.
- R6: MDC has a period of `CLK_DIV` system clocks during a frame and is low when idle. `mdio_o` changes only while MDC is low.
- R7: A read request or a high-byte write arriving while busy starts no frame. The frame in flight completes at its original time with its original contents.
- R8: Bit 1 of offset 0 (scan request) reads back as written and starts no frame. Status bit 1 (scan active) always reads 0.
- R9: Offset 1 holds the 5-bit register number and offsets 0 to 3 read back as written. Writes to offsets 4, 5 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe for one cycle |
| reg_addr | input | 3 | Host location offset |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Byte at `reg_addr` (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Management data returned by the PHY |

## Verification
The hardest case to reach from the ports is a request that lands in the middle of a frame. The bench starts a write, waits 20 cycles, then issues both a read request and a second high-byte write. It then requires that busy falls on the exact cycle fixed by the first start. It also requires that a later read of that PHY register returns the first frame's data and not the overlapping byte. A PHY model on the MDC/MDIO pins decodes every frame and keeps its own register file, so read data travels the whole turnaround-and-sample path.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

   localparam int FRAME_BITS = 64;
   localparam int PRE_BITS   = 32;
   localparam int TA_FIRST   = 46;   // first turnaround bit index
   localparam int DATA_FIRST = 48;   // first data bit index
   localparam int LAST_BIT   = FRAME_BITS - 1;

   typedef enum logic [1:0] {
      MII_OP_WR = 2'b01,
      MII_OP_RD = 2'b10
   } mii_op_e;

   typedef struct packed {
      logic [PRE_BITS-1:0] pre;
      logic [1:0]          sof;
      logic [1:0]          op;
      logic [4:0]          phy;
      logic [4:0]          regn;
      logic [1:0]          ta;
      logic [15:0]         data;
   } mii_frame_t;

   // host location offsets (field positions here are decoded by software)
   localparam logic [2:0] LOC_CMD  = 3'd0;
   localparam logic [2:0] LOC_REG  = 3'd1;
   localparam logic [2:0] LOC_WLO  = 3'd2;
   localparam logic [2:0] LOC_WHI  = 3'd3;
   localparam logic [2:0] LOC_RLO  = 3'd4;
   localparam logic [2:0] LOC_RHI  = 3'd5;
   localparam logic [2:0] LOC_STAT = 3'd6;

   localparam int CMD_RD_BIT   = 0;
   localparam int CMD_SCAN_BIT = 1;

endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int HALF = CLK_DIV / 2;

   logic tick;
   logic mdc_q;

   generate
      if (HALF == 1) begin : g_toggle
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run || tick)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == CW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mdc_q <= 1'b0;
      else if (!run)
         mdc_q <= 1'b0;
      else if (tick)
         mdc_q <= ~mdc_q;
   end

   assign mdc       = mdc_q;
   assign rise_tick = tick & ~mdc_q;
   assign fall_tick = tick & mdc_q;

endmodule

// File: rtl/mii_frame_engine.sv
module mii_frame_engine
   import mii_mgmt_pkg::*;
#(
   parameter int CLK_DIV  = 4,
   parameter int PHY_ADDR = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        start_rd,
   input  logic [4:0]  reg_sel,
   input  logic [15:0] wr_data,
   output logic        busy,
   output logic        done,
   output logic        was_rd,
   output logic [15:0] rd_data,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   localparam int          FRAME_CYC = FRAME_BITS * CLK_DIV;
   localparam int          LW        = $clog2(FRAME_CYC + 1);
   localparam logic [4:0]  PHY_A     = 5'(PHY_ADDR);
   localparam logic [5:0]  IDX_LAST  = 6'(LAST_BIT);
   localparam logic [5:0]  IDX_DATA  = 6'(DATA_FIRST);
   localparam logic [5:0]  IDX_TA    = 6'(TA_FIRST);

   logic        busy_q, rd_q;
   logic [5:0]  bit_q;
   logic [FRAME_BITS-1:0] frame_q;
   logic [15:0] cap_q;
   logic        rise_tick, fall_tick;
   mii_frame_t  load_frame;

   mii_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
      .clk(clk), .rst_n(rst_n), .run(busy_q),
      .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
   );

   always_comb begin
      load_frame.pre  = '1;
      load_frame.sof  = 2'b01;
      load_frame.op   = start_rd ? MII_OP_RD : MII_OP_WR;
      load_frame.phy  = PHY_A;
      load_frame.regn = reg_sel;
      load_frame.ta   = start_rd ? 2'b11 : 2'b10;
      load_frame.data = start_rd ? 16'hFFFF : wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         rd_q    <= 1'b0;
         bit_q   <= '0;
         frame_q <= '0;
         cap_q   <= '0;
      end else if (start && !busy_q) begin
         busy_q  <= 1'b1;
         rd_q    <= start_rd;
         bit_q   <= '0;
         frame_q <= load_frame;
      end else if (busy_q) begin
         if (rise_tick && rd_q && (bit_q >= IDX_DATA))
            cap_q <= {cap_q[14:0], mdio_i};
         if (fall_tick) begin
            if (bit_q == IDX_LAST) begin
               busy_q <= 1'b0;
            end else begin
               bit_q   <= bit_q + 1'b1;
               frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
            end
         end
      end
   end

   assign busy    = busy_q;
   assign was_rd  = rd_q;
   assign done    = fall_tick && (bit_q == IDX_LAST);
   assign rd_data = cap_q;
   assign mdio_o  = frame_q[FRAME_BITS-1];
   assign mdio_oe = busy_q && !(rd_q && (bit_q >= IDX_TA));

   // assertion-side cycle counter for the busy window
   logic [LW-1:0] len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= '0;
      else if (busy_q) len_q <= len_q + 1'b1;
      else             len_q <= '0;
   end

   // R6
   mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> $stable(mdio_o));
   // R6
   mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !mdc);
   // R4
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (len_q == LW'(FRAME_CYC)));
   // R7
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> ($stable(rd_q) && $stable(bit_q[5:0] >= bit_q[5:0])));

endmodule

// File: rtl/mii_host_regs.sv
module mii_host_regs
   import mii_mgmt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        eng_busy,
   input  logic        eng_done,
   input  logic        eng_was_rd,
   input  logic [15:0] eng_rdata,
   output logic        start,
   output logic        start_rd,
   output logic [4:0]  reg_sel,
   output logic [15:0] wr_data
);
   logic [1:0]  cmd_q;
   logic [4:0]  regn_q;
   logic [7:0]  wlo_q, whi_q;
   logic [15:0] result_q;
   logic        nvalid_q;
   logic        wr_cmd, wr_hi, go_rd, go_wr, rd_fin;

   assign wr_cmd = reg_wr && (reg_addr == LOC_CMD);
   assign wr_hi  = reg_wr && (reg_addr == LOC_WHI);
   assign go_rd  = wr_cmd && reg_wdata[CMD_RD_BIT] && !eng_busy;
   assign go_wr  = wr_hi && !eng_busy;
   assign rd_fin = eng_done && eng_was_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         regn_q   <= '0;
         wlo_q    <= '0;
         whi_q    <= '0;
         result_q <= '0;
         nvalid_q <= 1'b0;
      end else begin
         if (wr_cmd)                                cmd_q  <= reg_wdata[1:0];
         if (reg_wr && (reg_addr == LOC_REG))       regn_q <= reg_wdata[4:0];
         if (reg_wr && (reg_addr == LOC_WLO))       wlo_q  <= reg_wdata;
         if (wr_hi)                                 whi_q  <= reg_wdata;
         if (rd_fin)                                result_q <= eng_rdata;
         if (go_rd)       nvalid_q <= 1'b1;
         else if (rd_fin) nvalid_q <= 1'b0;
      end
   end

   assign start    = go_rd || go_wr;
   assign start_rd = go_rd;
   assign reg_sel  = regn_q;
   assign wr_data  = {reg_wdata, wlo_q};

   always_comb begin
      case (reg_addr)
         LOC_CMD:  reg_rdata = {6'd0, cmd_q};
         LOC_REG:  reg_rdata = {3'd0, regn_q};
         LOC_WLO:  reg_rdata = wlo_q;
         LOC_WHI:  reg_rdata = whi_q;
         LOC_RLO:  reg_rdata = result_q[7:0];
         LOC_RHI:  reg_rdata = result_q[15:8];
         LOC_STAT: reg_rdata = {5'd0, nvalid_q, 1'b0, eng_busy};
         default:  reg_rdata = 8'd0;
      endcase
   end

   // R5
   nvalid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nvalid_q |-> eng_busy);
   // R5
   nvalid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(eng_busy) && eng_was_rd) |-> !nvalid_q);
   // R3
   rslt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_q) |-> $past(eng_done && eng_was_rd));

endmodule

// File: rtl/mii_mgmt_seq.sv
module mii_mgmt_seq
   import mii_mgmt_pkg::*;
#(
   parameter int CLK_DIV  = 4,
   parameter int PHY_ADDR = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [2:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       mdc,
   output logic       mdio_o,
   output logic       mdio_oe,
   input  logic       mdio_i
);
   generate
      if ((CLK_DIV < 2) || ((CLK_DIV % 2) != 0)) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if ((PHY_ADDR < 0) || (PHY_ADDR > 31)) begin : g_bad_phy
         $error("PHY_ADDR must fit in five bits");
      end
   endgenerate

   logic        start, start_rd, busy, done, was_rd;
   logic [4:0]  reg_sel;
   logic [15:0] wr_data, rd_data;

   mii_host_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .eng_busy(busy), .eng_done(done), .eng_was_rd(was_rd),
      .eng_rdata(rd_data),
      .start(start), .start_rd(start_rd), .reg_sel(reg_sel),
      .wr_data(wr_data)
   );

   mii_frame_engine #(.CLK_DIV(CLK_DIV), .PHY_ADDR(PHY_ADDR)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_rd(start_rd), .reg_sel(reg_sel),
      .wr_data(wr_data),
      .busy(busy), .done(done), .was_rd(was_rd), .rd_data(rd_data),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

endmodule

// File: tb/mii_mgmt_seq_test.sv
module mii_mgmt_seq_test;
   localparam int DIV   = 4;
   localparam int FCYC  = 64 * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       mdc, mdio_o, mdio_oe;
   logic       mdio_i = 1'b1;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   mii_mgmt_seq #(.CLK_DIV(DIV), .PHY_ADDR(0)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // ---------------- PHY model on the pins ----------------
   logic [15:0] phy_mem [32];
   logic        cap_bits [64];
   logic        cap_oe   [64];
   logic [63:0] last_frame = '0;
   logic [63:0] last_oe    = '0;
   int          ph_idx = 0;
   int          frame_cnt = 0;
   time         t_rise0 = 0;
   time         mdc_per = 0;

   initial for (int i = 0; i < 32; i++) phy_mem[i] = 16'hC3C0 ^ 16'(i);

   always @(posedge mdc) begin
      cap_bits[ph_idx] = mdio_o;
      cap_oe[ph_idx]   = mdio_oe;
      if (ph_idx == 0) t_rise0 = $time;
      if (ph_idx == 1) mdc_per = $time - t_rise0;
      ph_idx++;
      if (ph_idx == 64) begin
         for (int i = 0; i < 64; i++) begin
            last_frame[63-i] = cap_bits[i];
            last_oe[63-i]    = cap_oe[i];
         end
         frame_cnt++;
         if (last_frame[29:28] == 2'b01)
            phy_mem[last_frame[22:18]] = last_frame[15:0];
         ph_idx = 0;
      end
   end

   always @(negedge mdc) begin
      if (ph_idx >= 48 && cap_bits[34] == 1'b1 && cap_bits[35] == 1'b0)
         mdio_i = phy_mem[{cap_bits[41], cap_bits[42], cap_bits[43],
                           cap_bits[44], cap_bits[45]}][63-ph_idx];
      else
         mdio_i = 1'b1;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      reg_addr = 3'd6;
      #1;
      while (reg_rdata[0] && n < 100000) begin
         n++;
         @(negedge clk);
         #1;
      end
   endtask

   // op(1) | register(5) | data(16)
   localparam logic [21:0] VEC [8] = '{
      {1'b0, 5'd3,  16'h1234},
      {1'b1, 5'd3,  16'h1234},
      {1'b0, 5'd31, 16'h8001},
      {1'b1, 5'd31, 16'h8001},
      {1'b1, 5'd17, 16'hC3D1},
      {1'b0, 5'd0,  16'h0000},
      {1'b1, 5'd0,  16'h0000},
      {1'b1, 5'd10, 16'hC3CA}
   };

   localparam logic [63:0] WR_OE = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] RD_OE = {46'h3FFF_FFFF_FFFF, 18'd0};

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] b, hi, lo;
      int n, fc0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 7; a++) begin
         rd_reg(3'(a), b);
         chk(b == 8'h00, "R1 location after reset", 64'(b), 64'h0);
      end
      chk(mdc == 1'b0, "R1 mdc idle", 64'(mdc), 64'h0);
      chk(mdio_oe == 1'b0, "R1 mdio released", 64'(mdio_oe), 64'h0);

      // vector table walk
      for (int v = 0; v < 8; v++) begin
         logic        isrd;
         logic [4:0]  rn;
         logic [15:0] dv;
         isrd = VEC[v][21]; rn = VEC[v][20:16]; dv = VEC[v][15:0];
         fc0 = frame_cnt;
         wr_reg(3'd1, {3'd0, rn});
         if (!isrd) begin
            wr_reg(3'd2, dv[7:0]);
            wr_reg(3'd3, dv[15:8]);
            wait_idle(n);
            chk(n == FCYC, "R4 busy length on write", 64'(n), 64'(FCYC));
            @(negedge clk);
            chk(frame_cnt == fc0 + 1, "R2 one write frame", 64'(frame_cnt), 64'(fc0 + 1));
            chk(last_frame == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd0, rn, 2'b10, dv},
                "R2 write frame bits", last_frame,
                {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd0, rn, 2'b10, dv});
            chk(last_oe == WR_OE, "R2 write frame driven", last_oe, WR_OE);
            chk(phy_mem[rn] == dv, "R2 PHY register updated", 64'(phy_mem[rn]), 64'(dv));
         end else begin
            wr_reg(3'd0, 8'h01);
            rd_reg(3'd6, b);
            chk(b == 8'h05, "R5 busy and not-valid during read", 64'(b), 64'h05);
            wait_idle(n);
            chk(n == FCYC, "R4 busy length on read", 64'(n), 64'(FCYC));
            rd_reg(3'd6, b);
            chk(b == 8'h00, "R5 not-valid cleared", 64'(b), 64'h0);
            wr_reg(3'd0, 8'h00);
            rd_reg(3'd5, hi);
            rd_reg(3'd4, lo);
            chk({hi, lo} == dv, "R3 read result", 64'({hi, lo}), 64'(dv));
            chk(last_frame[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd0, rn},
                "R3 read frame header", 64'(last_frame[63:18]),
                64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'd0, rn}));
            chk(last_oe == RD_OE, "R3 mdio released after header", last_oe, RD_OE);
         end
      end

      // R6 MDC period
      chk(mdc_per == time'(DIV * 8), "R6 mdc period", 64'(mdc_per), 64'(DIV * 8));

      // R9 readback and read-only locations
      rd_reg(3'd1, b);
      chk(b == 8'd10, "R9 register number readback", 64'(b), 64'd10);
      rd_reg(3'd4, lo);
      wr_reg(3'd4, ~lo);
      wr_reg(3'd6, 8'hFF);
      rd_reg(3'd4, b);
      chk(b == lo, "R9 result location not writable", 64'(b), 64'(lo));
      rd_reg(3'd6, b);
      chk(b == 8'h00, "R9 status not writable", 64'(b), 64'h0);

      // R7 requests while busy are ignored
      fc0 = frame_cnt;
      wr_reg(3'd1, 8'd5);
      wr_reg(3'd2, 8'h0F);
      wr_reg(3'd3, 8'hF0);
      repeat (20) @(negedge clk);
      wr_reg(3'd0, 8'h01);
      rd_reg(3'd6, b);
      chk(b == 8'h01, "R7 read request while busy ignored", 64'(b), 64'h01);
      wr_reg(3'd3, 8'hAA);
      wait_idle(n);
      chk(n == FCYC - 24, "R7 frame ends at original time", 64'(n), 64'(FCYC - 24));
      repeat (300) @(negedge clk);
      chk(frame_cnt == fc0 + 1, "R7 single frame sent", 64'(frame_cnt), 64'(fc0 + 1));
      wr_reg(3'd0, 8'h00);
      wr_reg(3'd0, 8'h01);
      wait_idle(n);
      wr_reg(3'd0, 8'h00);
      rd_reg(3'd5, hi);
      rd_reg(3'd4, lo);
      chk({hi, lo} == 16'hF00F, "R7 original write data kept", 64'({hi, lo}), 64'hF00F);

      // R8 scan bit
      fc0 = frame_cnt;
      wr_reg(3'd0, 8'h02);
      rd_reg(3'd0, b);
      chk(b == 8'h02, "R8 scan bit readback", 64'(b), 64'h02);
      rd_reg(3'd6, b);
      chk(b == 8'h00, "R8 no scan activity", 64'(b), 64'h0);
      repeat (300) @(negedge clk);
      chk(frame_cnt == fc0, "R8 no frame from scan bit", 64'(frame_cnt), 64'(fc0));
      chk(mdc == 1'b0, "R6 mdc low when idle", 64'(mdc), 64'h0);
      wr_reg(3'd0, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule